// File: doc/BRIEF.md
# Maintenance address translation windows

This block turns a word address from a local memory-mapped request into the 21-bit configuration offset used by an outgoing serial-link maintenance transaction. It holds a parameterized set of translation windows. Each window has four 32-bit registers (match base, match mask with an enable bit, replacement offset and control), and a small register port writes and reads them. The port is addressed by window index and register select.

Requests arrive on a valid/ready stream. An accepted request is compared against every enabled window. The lowest-index window that matches is selected, and the result appears one clock later on a valid/ready result stream. The result carries the merged configuration offset, the selected window's destination ID and hop count, the window index and a miss flag.

Back-pressure rules: a result stays on the outputs unchanged while `rsp_valid` is high and `rsp_ready` is low. `req_ready` is high whenever the result slot is empty or is being drained in the same cycle, so a request can be accepted on every clock when the consumer is always ready. A request is taken only on a clock where `req_valid` and `req_ready` are both high.

Top module: `mnt_xlate_windows`

## Requirements
- R1: After reset every window register reads zero, so every window is disabled, and `rsp_valid` is low.
- R2: The register port selects a window with `cfg_addr[CA_W-1:2]` and a register with `cfg_addr[1:0]` (0 base, 1 mask, 2 offset, 3 control). A write is applied at the clock edge. `cfg_rdata` shows the addressed register combinationally, so a read in the same cycle as a write returns the old value. A window index at or above NWIN ignores writes and reads as zero.
- R3: A window takes part in matching only while bit 0 of its mask register is 1.
- R4: An enabled window hits when `(req_addr[23:1] & mask[25:3]) == base[25:3]`, where `req_addr` holds bits [25:2] of a byte address.
- R5: When several enabled windows hit, the lowest-index one is selected, and its index is output on `rsp_win`.
- R6: On a hit, `rsp_coff = (offset[23:3] & mask[23:3]) | (req_addr[21:1] & ~mask[23:3])`, where offset[23:0] is the window's offset field.
- R7: When no enabled window hits, `rsp_miss` is 1 and `rsp_coff`, `rsp_win`, `rsp_dest` and `rsp_hop` are all zero.
- R8: On a hit, `rsp_dest` is bits [31:16] and `rsp_hop` is bits [7:0] of the selected window's control register.
- R9: A request accepted at a clock edge gives a valid result right after that edge, computed from the register contents before that edge. A write in the same cycle affects only later requests.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, every result output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CA_W | Window index and register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_addr | input | 24 | Word address (byte address bits 25:2) |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_miss | output | 1 | No enabled window matched |
| rsp_win | output | 4 | Selected window index |
| rsp_coff | output | 21 | Configuration offset |
| rsp_dest | output | 16 | Destination ID of the selected window |
| rsp_hop | output | 8 | Hop count of the selected window |

## Verification
The bench builds overlapping windows so that a lower-index window must beat a wider one. A design with reversed priority would then report the wrong index and offset. It also places a disabled window whose base would otherwise match, which catches a design that ignores the enable bit. A control register is rewritten in the same cycle as a request aimed at that window, to catch a design that forwards new register contents into an in-flight lookup. Long random stalls on the result side catch result data that changes under back-pressure or a request taken while the slot is full. Writes to window indices above the configured count catch aliasing onto real windows.

// File: rtl/mxw_pkg.sv
package mxw_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 24;
  localparam int COFF_W = 21;
  localparam int DEST_W = 16;
  localparam int HOP_W  = 8;
  localparam int WIN_W  = 4;
  localparam int EN_BIT = 0;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_OFFS = 2'd2,
    SEL_CTRL = 2'd3
  } regsel_e;

  typedef struct packed {
    logic [REG_W-1:0] ctrl;
    logic [REG_W-1:0] offs;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] base;
  } win_regs_t;

  typedef struct packed {
    logic              miss;
    logic [WIN_W-1:0]  win;
    logic [COFF_W-1:0] coff;
    logic [DEST_W-1:0] dest;
    logic [HOP_W-1:0]  hop;
  } xlate_res_t;
endpackage

// File: rtl/mxw_regfile.sv
module mxw_regfile
  import mxw_pkg::*;
#(
  parameter int NWIN = 6,
  parameter int CA_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CA_W-1:0]  cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output win_regs_t        regs [NWIN]
);
  localparam int SEL_W = CA_W - 2;

  logic [SEL_W-1:0] widx;
  regsel_e          rsel;

  assign widx = cfg_addr[CA_W-1:2];
  assign rsel = regsel_e'(cfg_addr[1:0]);

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[w] <= '0;
      end else if (cfg_we && widx == SEL_W'(w)) begin
        case (rsel)
          SEL_BASE: regs[w].base <= cfg_wdata;
          SEL_MASK: regs[w].mask <= cfg_wdata;
          SEL_OFFS: regs[w].offs <= cfg_wdata;
          default:  regs[w].ctrl <= cfg_wdata;
        endcase
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (widx == SEL_W'(w)) begin
        case (rsel)
          SEL_BASE: cfg_rdata = regs[w].base;
          SEL_MASK: cfg_rdata = regs[w].mask;
          SEL_OFFS: cfg_rdata = regs[w].offs;
          default:  cfg_rdata = regs[w].ctrl;
        endcase
      end
    end
  end

  // R2
  rd_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we && (int'(widx) < NWIN) |=> $stable(cfg_addr) |-> cfg_rdata == $past(cfg_wdata));
endmodule

// File: rtl/mxw_match.sv
module mxw_match
  import mxw_pkg::*;
#(
  parameter int NWIN = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  win_regs_t         regs [NWIN],
  output logic [NWIN-1:0]   sel_vec,
  output logic [WIN_W-1:0]  sel_idx,
  output logic              any_hit
);
  logic [NWIN-1:0] hit_vec;
  logic [NWIN-1:0] en_vec;

  for (genvar w = 0; w < NWIN; w++) begin : g_cmp
    assign en_vec[w]  = regs[w].mask[EN_BIT];
    assign hit_vec[w] = en_vec[w] &&
                        ((addr[23:1] & regs[w].mask[25:3]) == regs[w].base[25:3]);
  end

  assign sel_vec = hit_vec & (~hit_vec + NWIN'(1));
  assign any_hit = |hit_vec;

  always_comb begin
    sel_idx = '0;
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (hit_vec[w]) sel_idx = WIN_W'(w);
    end
  end

  // R5
  one_winner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_vec));
  // R5
  idx_agrees_chk: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> sel_vec[sel_idx]);
  // R3
  enabled_only_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_vec & ~en_vec) == '0);
endmodule

// File: rtl/mxw_compose.sv
module mxw_compose
  import mxw_pkg::*;
#(
  parameter int NWIN = 6
) (
  input  logic              [ADDR_W-1:0] addr,
  input  win_regs_t                      regs [NWIN],
  input  logic              [NWIN-1:0]   sel_vec,
  input  logic              [WIN_W-1:0]  sel_idx,
  input  logic                           any_hit,
  output xlate_res_t                     res
);
  win_regs_t chosen;

  always_comb begin
    chosen = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (sel_vec[w]) chosen = regs[w];
    end
  end

  always_comb begin
    res = '0;
    res.miss = !any_hit;
    if (any_hit) begin
      res.win  = sel_idx;
      res.coff = (chosen.offs[23:3] & chosen.mask[23:3]) |
                 (addr[21:1] & ~chosen.mask[23:3]);
      res.dest = chosen.ctrl[31:16];
      res.hop  = chosen.ctrl[7:0];
    end
  end
endmodule

// File: rtl/mxw_outreg.sv
module mxw_outreg
  import mxw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  xlate_res_t in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output xlate_res_t out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R9
  accept_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);
  // R1
  reset_empty_chk: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: rtl/mnt_xlate_windows.sv
module mnt_xlate_windows
  import mxw_pkg::*;
#(
  parameter int NWIN = 6,
  localparam int IDX_B = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int CA_W  = IDX_B + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CA_W-1:0]   cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_miss,
  output logic [WIN_W-1:0]  rsp_win,
  output logic [COFF_W-1:0] rsp_coff,
  output logic [DEST_W-1:0] rsp_dest,
  output logic [HOP_W-1:0]  rsp_hop
);
  win_regs_t        regs [NWIN];
  logic [NWIN-1:0]  sel_vec;
  logic [WIN_W-1:0] sel_idx;
  logic             any_hit;
  xlate_res_t       res_d;
  xlate_res_t       res_q;

  mxw_regfile #(.NWIN(NWIN), .CA_W(CA_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .regs(regs)
  );

  mxw_match #(.NWIN(NWIN)) u_match (
    .clk(clk), .rst(rst), .addr(req_addr), .regs(regs),
    .sel_vec(sel_vec), .sel_idx(sel_idx), .any_hit(any_hit)
  );

  mxw_compose #(.NWIN(NWIN)) u_comp (
    .addr(req_addr), .regs(regs), .sel_vec(sel_vec),
    .sel_idx(sel_idx), .any_hit(any_hit), .res(res_d)
  );

  mxw_outreg u_out (
    .clk(clk), .rst(rst), .in_valid(req_valid), .in_ready(req_ready),
    .in_data(res_d), .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_data(res_q)
  );

  assign rsp_miss = res_q.miss;
  assign rsp_win  = res_q.win;
  assign rsp_coff = res_q.coff;
  assign rsp_dest = res_q.dest;
  assign rsp_hop  = res_q.hop;

  // R7
  miss_blank_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_miss |-> rsp_coff == '0 && rsp_win == '0 &&
                              rsp_dest == '0 && rsp_hop == '0);
  // R10
  ready_rule_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready == (!rsp_valid || rsp_ready));
endmodule

// File: tb/mnt_xlate_windows_test.sv
module mnt_xlate_windows_test;
  localparam int NWIN = 6;
  localparam int CA_W = 5;
  localparam int NSLOT = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [CA_W-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_miss;
  logic [3:0]  rsp_win;
  logic [20:0] rsp_coff;
  logic [15:0] rsp_dest;
  logic [7:0]  rsp_hop;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  logic [31:0] m_base [NSLOT];
  logic [31:0] m_mask [NSLOT];
  logic [31:0] m_offs [NSLOT];
  logic [31:0] m_ctrl [NSLOT];
  logic        m_valid;
  logic        m_miss;
  logic [3:0]  m_win;
  logic [20:0] m_coff;
  logic [15:0] m_dest;
  logic [7:0]  m_hop;

  always #5 clk = ~clk;

  mnt_xlate_windows #(.NWIN(NWIN)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_miss(rsp_miss), .rsp_win(rsp_win),
    .rsp_coff(rsp_coff), .rsp_dest(rsp_dest), .rsp_hop(rsp_hop)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [CA_W-1:0] a);
    int w = int'(a[CA_W-1:2]);
    if (w >= NWIN) return 32'h0;
    case (a[1:0])
      2'd0: return m_base[w];
      2'd1: return m_mask[w];
      2'd2: return m_offs[w];
      default: return m_ctrl[w];
    endcase
  endfunction

  // picks the first enabled matching window, scanning upward
  task automatic m_lookup(input logic [23:0] a);
    bit found = 0;
    m_miss = 1; m_win = 0; m_coff = 0; m_dest = 0; m_hop = 0;
    for (int w = 0; w < NWIN; w++) begin
      if (!found && m_mask[w][0] &&
          ((a[23:1] & m_mask[w][25:3]) == m_base[w][25:3])) begin
        found  = 1;
        m_miss = 0;
        m_win  = 4'(w);
        m_coff = (m_offs[w][23:3] & m_mask[w][23:3]) | (a[21:1] & ~m_mask[w][23:3]);
        m_dest = m_ctrl[w][31:16];
        m_hop  = m_ctrl[w][7:0];
      end
    end
  endtask

  // one clock: called at a falling edge, returns at the next falling edge
  task automatic step(input bit we, input logic [CA_W-1:0] ca, input logic [31:0] wd,
                      input bit rv, input logic [23:0] ra, input bit rr);
    bit exp_ready;
    cfg_we = we; cfg_addr = ca; cfg_wdata = wd;
    req_valid = rv; req_addr = ra; rsp_ready = rr;
    #1;
    exp_ready = !m_valid || rr;
    check("R10 req_ready", 32'(req_ready), 32'(exp_ready));
    check("R2 cfg_rdata", cfg_rdata, m_read(ca));
    // R9: lookup uses registers as they stand before this edge
    if (rv && exp_ready) begin
      m_lookup(ra);
      m_valid = 1;
    end else if (rr) begin
      m_valid = 0;
    end
    if (we && int'(ca[CA_W-1:2]) < NWIN) begin
      case (ca[1:0])
        2'd0: m_base[int'(ca[CA_W-1:2])] = wd;
        2'd1: m_mask[int'(ca[CA_W-1:2])] = wd;
        2'd2: m_offs[int'(ca[CA_W-1:2])] = wd;
        default: m_ctrl[int'(ca[CA_W-1:2])] = wd;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check("R9 R10 rsp_valid", 32'(rsp_valid), 32'(m_valid));
    if (m_valid) begin
      check("R7 rsp_miss", 32'(rsp_miss), 32'(m_miss));
      check("R3 R4 R5 rsp_win", 32'(rsp_win), 32'(m_win));
      check("R6 rsp_coff", 32'(rsp_coff), 32'(m_coff));
      check("R8 rsp_dest", 32'(rsp_dest), 32'(m_dest));
      check("R8 rsp_hop", 32'(rsp_hop), 32'(m_hop));
    end
  endtask

  task automatic wr(input int w, input int r, input logic [31:0] d);
    step(1, CA_W'((w << 2) | r), d, 0, 0, 1);
  endtask

  task automatic req(input logic [23:0] a);
    step(0, 0, 0, 1, a, 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < NSLOT; w++) begin
      m_base[w] = 0; m_mask[w] = 0; m_offs[w] = 0; m_ctrl[w] = 0;
    end
    m_valid = 0; m_miss = 1; m_win = 0; m_coff = 0; m_dest = 0; m_hop = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    for (int a = 0; a < (1 << CA_W); a++) step(0, CA_W'(a), 0, 0, 0, 1);
    // R1 R7: every window disabled, so lookups miss
    req(24'h000000);
    req(24'h123456);

    // R3: window 0 matches region 0x12 but stays disabled
    wr(0, 0, 32'h0120_0000);
    wr(0, 1, 32'h03F0_0000);
    wr(0, 2, 32'h00FF_FFF8);
    wr(0, 3, 32'hDEAD_00EE);
    // window 1: narrow region 0x12 in byte bits 25:20
    wr(1, 0, 32'h0120_0000);
    wr(1, 1, 32'h03F0_0001);
    wr(1, 2, 32'h00AB_CDE8);
    wr(1, 3, 32'h1234_0056);
    // window 2: wide region overlapping window 1
    wr(2, 0, 32'h0100_0000);
    wr(2, 1, 32'h0300_0001);
    wr(2, 2, 32'h0055_5558);
    wr(2, 3, 32'h0BEE_0007);
    // window 5: mask with fine bits, highest index
    wr(5, 0, 32'h0000_0018);
    wr(5, 1, 32'h03FF_FF19);
    wr(5, 2, 32'h00FF_FFF8);
    wr(5, 3, 32'hCAFE_00A5);
    // R2: out-of-range windows ignore writes and read as zero
    wr(6, 1, 32'hFFFF_FFFF);
    wr(7, 3, 32'h1111_1111);
    step(0, CA_W'(6 << 2 | 1), 0, 0, 0, 1);
    step(0, CA_W'(7 << 2 | 3), 0, 0, 0, 1);

    // R4 R5 R6: hits in window 1 region beat window 2
    req(24'h480000);
    req(24'h4BFFFF);
    req(24'h4A5A5A);
    // window 2 only
    req(24'h400001);
    req(24'h7FFFFF);
    // window 5 exact match, and miss
    req(24'h00000C);
    req(24'h00000D);
    req(24'h00000E);
    req(24'hC00000);

    // R9: control write in the same cycle as a request to window 1
    step(1, CA_W'(1 << 2 | 3), 32'h7777_0099, 1, 24'h480010, 1);
    req(24'h480010);
    // R3: disabling window 1 hands its region to window 2
    wr(1, 1, 32'h03F0_0000);
    req(24'h480010);

    // R10: stall the result, then drain
    step(0, 0, 0, 1, 24'h480020, 0);
    step(0, 0, 0, 1, 24'h000030, 0);
    step(0, 0, 0, 1, 24'h000030, 0);
    step(0, 0, 0, 0, 0, 1);

    // random traffic with random writes, stalls and targeted addresses
    for (int i = 0; i < 3000; i++) begin
      bit we = ($urandom_range(0, 5) == 0);
      logic [CA_W-1:0] ca = CA_W'($urandom);
      logic [31:0] wd = $urandom;
      bit rv = ($urandom_range(0, 3) != 0);
      bit rr = ($urandom_range(0, 3) != 0);
      int tw = $urandom_range(0, NWIN - 1);
      logic [23:0] ra = 24'($urandom);
      if (ca[1:0] == 2'd1) wd[0] = $urandom_range(0, 3) != 0;
      if ($urandom_range(0, 2) != 0)
        ra = ({m_base[tw][25:3], 1'b0} & {m_mask[tw][25:3], 1'b1}) |
             (ra & ~{m_mask[tw][25:3], 1'b0});
      step(we, ca, wd, rv, ra, rr);
    end
    step(0, 0, 0, 0, 0, 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule